// File: doc/BRIEF.md
# Look-Ahead Pruning Threshold Unit for a 64-State Viterbi Decoder

This block produces the pruning threshold and a per-state keep/purge decision for a 64-state Viterbi decoder that discards unlikely paths. A straightforward pruning decoder searches the new path metrics for their minimum, adds a margin and compares. That search sits inside the add-compare-select feedback loop. This unit avoids it. It predicts the minimum from data that is already available earlier.

The path metrics of each step are reduced to four cluster minima and registered. The cluster membership depends on the state index modulo 4. In the next step those minima are combined with the minima of four branch-metric groups and registered again. In the step after that, the two partial results are completed with the even-index and odd-index branch-metric minima of the current step. The margin is then added with saturation. Every new path metric is compared against the resulting threshold in the same cycle in which the add-compare-select unit presents it.

All metrics are unsigned and share one fixed-point format with 3 fractional bits. Every clock cycle is one trellis step. The path metrics and branch metrics of a step arrive together.

Top module: `tprune_thresh`

## Requirements
- R1: State i (0..63) is assigned to cluster c = {i[0], i[1]}. This puts remainder 0 in cluster 0, remainder 2 in cluster 1, remainder 1 in cluster 2 and remainder 3 in cluster 3. Cmin[c] is the minimum path metric of cluster c, taken from the path metrics presented two steps before the current one.
- R2: Branch metric j (0..15) is assigned to group g = {j[0], j[1]}, and Gmin[g] is the group minimum from the previous step. The unit forms A = min(Cmin0+Gmin0, Cmin1+Gmin1, Cmin2+Gmin3, Cmin3+Gmin2) and B = min(Cmin0+Gmin1, Cmin1+Gmin0, Cmin2+Gmin2, Cmin3+Gmin3), without truncation.
- R3: The predicted best metric is min(A + E, B + O). E is the minimum of the current step's branch metrics with even index, and O is the minimum of those with odd index.
- R4: `threshold` = predicted best + effective margin. `margin` is unsigned with 3 fractional bits. Any value below 3 (0.375) is treated as 3.
- R5: The threshold addition saturates at 4095. It never wraps.
- R6: `keepFlags[i]` is 1 when `pathMetrics[12*i +: 12]` is less than or equal to `threshold`. It is 0 when the metric is strictly greater.
- R7: `rst` is synchronous. While `rst` is high, and in the first two steps after it falls, `threshold` reads 4095 and all 64 flags read 1. Valid prediction starts with the third step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one trellis step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pathMetrics | input | 768 | New path metrics of this step, state i at bits [12*i +: 12] |
| branchMetrics | input | 128 | Branch metrics of this step, metric j at bits [8*j +: 8] |
| margin | input | 6 | Pruning margin, 3 fractional bits |
| threshold | output | 12 | Pruning threshold for this step |
| keepFlags | output | 64 | 1 = keep state i, 0 = purge |

## Verification
The bench places path metrics at exactly the threshold and one step to each side of it in every step. A comparator that uses the wrong relation, or that is off by one, therefore flips a flag at once.

Margins of 0 to 2 are applied to expose a missing floor clamp. Near-full-scale metrics are applied to expose a wrapping adder, which would produce a tiny threshold and purge almost every state.

Reset is applied again in the middle of the run. A warm-up count that is too short would show stale or cleared minima on the outputs. Randomized metrics with distinct group values expose a swapped cluster or group pairing, or a pipeline tap that is one step off, as threshold mismatches.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int NUM_CLUSTERS = 4;

  typedef struct packed {
    logic clear;   // clear the pipeline registers
    logic primed;  // both pipeline stages hold data of this run
  } tpt_strobe_t;
endpackage

// File: rtl/tpt_ctrl.sv
module tpt_ctrl
  import tpt_pkg::*;
#(
  parameter int FILL_STEPS = 2
) (
  input  logic        clk,
  input  logic        rst,
  output tpt_strobe_t strobes
);
  localparam int CW = $clog2(FILL_STEPS + 1);

  logic [CW-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (fillCnt != CW'(FILL_STEPS)) fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    strobes.clear  = rst;
    strobes.primed = (fillCnt == CW'(FILL_STEPS)) && !rst;
  end
endmodule

// File: rtl/tpt_cluster_min.sv
module tpt_cluster_min #(
  parameter int PMW    = 12,
  parameter int NSTATE = 64
) (
  input  logic [NSTATE*PMW-1:0]  pmFlat,
  output logic [3:0][PMW-1:0]    clusterMin
);
  localparam int CSZ   = NSTATE / 4;
  localparam int GROUP = 4;
  localparam int NSUB  = CSZ / GROUP;

  function automatic logic [PMW-1:0] min4(input logic [PMW-1:0] a, input logic [PMW-1:0] b,
                                          input logic [PMW-1:0] c, input logic [PMW-1:0] d);
    logic [PMW-1:0] ab, cd;
    ab = (a < b) ? a : b;
    cd = (c < d) ? c : d;
    return (ab < cd) ? ab : cd;
  endfunction

  for (genvar c = 0; c < 4; c++) begin : g_cluster
    // member k of cluster c sits at state 4*k + {c[0], c[1]}
    localparam int LOW = ((c & 1) << 1) | ((c >> 1) & 1);
    logic [PMW-1:0] subMin [NSUB];
    for (genvar q = 0; q < NSUB; q++) begin : g_first
      assign subMin[q] = min4(pmFlat[((4*(GROUP*q+0))+LOW)*PMW +: PMW],
                              pmFlat[((4*(GROUP*q+1))+LOW)*PMW +: PMW],
                              pmFlat[((4*(GROUP*q+2))+LOW)*PMW +: PMW],
                              pmFlat[((4*(GROUP*q+3))+LOW)*PMW +: PMW]);
    end
    assign clusterMin[c] = min4(subMin[0], subMin[1], subMin[2], subMin[3]);
  end
endmodule

// File: rtl/tpt_datapath.sv
module tpt_datapath
  import tpt_pkg::*;
#(
  parameter int PMW        = 12,
  parameter int BMW        = 8,
  parameter int NSTATE     = 64,
  parameter int NBM        = 16,
  parameter int TW         = 6,
  parameter int MIN_MARGIN = 3
) (
  input  logic                  clk,
  input  tpt_strobe_t           strobes,
  input  logic [NSTATE*PMW-1:0] pmFlat,
  input  logic [NBM*BMW-1:0]    bmFlat,
  input  logic [TW-1:0]         margin,
  output logic [PMW-1:0]        threshold,
  output logic [NSTATE-1:0]     keepFlags
);
  localparam int SW = PMW + 2;
  localparam logic [SW-1:0] PM_MAX = SW'({PMW{1'b1}});

  logic [3:0][PMW-1:0] clusterNow;
  logic [PMW-1:0]      clusterReg [NUM_CLUSTERS];
  logic [BMW-1:0]      groupMin   [NUM_CLUSTERS];
  logic [BMW-1:0]      evenMin, oddMin;
  logic [SW-1:0]       aNext, bNext, aReg, bReg;
  logic [SW-1:0]       bestPred, rawThr;
  logic [TW-1:0]       effMargin;
  logic [PMW-1:0]      thrSat;

  function automatic logic [SW-1:0] addCb(input logic [PMW-1:0] c, input logic [BMW-1:0] b);
    return SW'(c) + SW'(b);
  endfunction

  function automatic logic [SW-1:0] min2(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  tpt_cluster_min #(.PMW(PMW), .NSTATE(NSTATE)) u_cmin (
    .pmFlat    (pmFlat),
    .clusterMin(clusterNow)
  );

  // group and parity minima of the branch metrics presented this step
  always_comb begin
    for (int g = 0; g < NUM_CLUSTERS; g++) groupMin[g] = '1;
    evenMin = '1;
    oddMin  = '1;
    for (int j = 0; j < NBM; j++) begin
      if (bmFlat[j*BMW +: BMW] < groupMin[{j[0], j[1]}])
        groupMin[{j[0], j[1]}] = bmFlat[j*BMW +: BMW];
      if (j[0]) begin
        if (bmFlat[j*BMW +: BMW] < oddMin) oddMin = bmFlat[j*BMW +: BMW];
      end else begin
        if (bmFlat[j*BMW +: BMW] < evenMin) evenMin = bmFlat[j*BMW +: BMW];
      end
    end
  end

  // second look-ahead step: registered cluster minima plus group minima
  always_comb begin
    aNext = min2(min2(addCb(clusterReg[0], groupMin[0]), addCb(clusterReg[1], groupMin[1])),
                 min2(addCb(clusterReg[2], groupMin[3]), addCb(clusterReg[3], groupMin[2])));
    bNext = min2(min2(addCb(clusterReg[0], groupMin[1]), addCb(clusterReg[1], groupMin[0])),
                 min2(addCb(clusterReg[2], groupMin[2]), addCb(clusterReg[3], groupMin[3])));
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      for (int c = 0; c < NUM_CLUSTERS; c++) clusterReg[c] <= '0;
      aReg <= '0;
      bReg <= '0;
    end else begin
      for (int c = 0; c < NUM_CLUSTERS; c++) clusterReg[c] <= clusterNow[c];
      aReg <= aNext;
      bReg <= bNext;
    end
  end

  // final step and saturating threshold
  always_comb begin
    bestPred  = min2(aReg + SW'(evenMin), bReg + SW'(oddMin));
    effMargin = (margin < TW'(MIN_MARGIN)) ? TW'(MIN_MARGIN) : margin;
    rawThr    = bestPred + SW'(effMargin);
    thrSat    = (rawThr > PM_MAX) ? {PMW{1'b1}} : rawThr[PMW-1:0];
    threshold = strobes.primed ? thrSat : {PMW{1'b1}};
  end

  for (genvar i = 0; i < NSTATE; i++) begin : g_purge
    assign keepFlags[i] = !strobes.primed || (pmFlat[i*PMW +: PMW] <= thrSat);
  end
endmodule

// File: rtl/tprune_thresh.sv
module tprune_thresh
  import tpt_pkg::*;
#(
  parameter int PMW        = 12,
  parameter int BMW        = 8,
  parameter int NSTATE     = 64,
  parameter int NBM        = 16,
  parameter int TW         = 6,
  parameter int MIN_MARGIN = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSTATE*PMW-1:0] pathMetrics,
  input  logic [NBM*BMW-1:0]    branchMetrics,
  input  logic [TW-1:0]         margin,
  output logic [PMW-1:0]        threshold,
  output logic [NSTATE-1:0]     keepFlags
);
  tpt_strobe_t strobes;

  tpt_ctrl #(.FILL_STEPS(2)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  tpt_datapath #(
    .PMW(PMW), .BMW(BMW), .NSTATE(NSTATE), .NBM(NBM), .TW(TW), .MIN_MARGIN(MIN_MARGIN)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .pmFlat   (pathMetrics),
    .bmFlat   (branchMetrics),
    .margin   (margin),
    .threshold(threshold),
    .keepFlags(keepFlags)
  );
endmodule

// File: rtl/tprune_thresh_chk.sv
module tprune_thresh_chk #(
  parameter int PMW        = 12,
  parameter int NSTATE     = 64,
  parameter int MIN_MARGIN = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  primed,
  input logic [NSTATE*PMW-1:0] pathMetrics,
  input logic [PMW-1:0]        threshold,
  input logic [NSTATE-1:0]     keepFlags
);
  // R7
  reset_force_chk: assert property (@(posedge clk)
    rst |-> (threshold == {PMW{1'b1}}) && (&keepFlags));

  // R7
  warmup_force_chk: assert property (@(posedge clk)
    rst |=> (threshold == {PMW{1'b1}}) && (&keepFlags));

  // R7
  primed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed);

  // R4
  thr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    threshold >= PMW'(MIN_MARGIN));

  // R5
  sat_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (threshold == {PMW{1'b1}}) |-> (&keepFlags));

  for (genvar i = 0; i < NSTATE; i++) begin : g_rule
    // R6
    purge_rule_chk: assert property (@(posedge clk) disable iff (rst)
      keepFlags[i] == (pathMetrics[i*PMW +: PMW] <= threshold));
  end
endmodule

bind tprune_thresh tprune_thresh_chk #(
  .PMW(PMW), .NSTATE(NSTATE), .MIN_MARGIN(MIN_MARGIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .primed     (strobes.primed),
  .pathMetrics(pathMetrics),
  .threshold  (threshold),
  .keepFlags  (keepFlags)
);

// File: tb/sim_tprune_thresh.sv
module sim_tprune_thresh;
  localparam int NSTEP = 400;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [767:0] pathMetrics = '0;
  logic [127:0] branchMetrics = '0;
  logic [5:0]   margin = 6'd3;
  logic [11:0]  threshold;
  logic [63:0]  keepFlags;

  int checks = 0;
  int errors = 0;
  int t = 0;
  int sinceRst = 0;
  logic rstV = 1'b1;
  int marginV = 3;
  int pmBase = 400, pmSpread = 120, bmLo = 0, bmHi = 255;
  int seedDummy;

  logic [11:0] pmH [0:NSTEP-1][0:63];
  logic [7:0]  bmH [0:NSTEP-1][0:15];

  always #5 clk = ~clk;

  tprune_thresh u0 (
    .clk(clk), .rst(rst), .pathMetrics(pathMetrics), .branchMetrics(branchMetrics),
    .margin(margin), .threshold(threshold), .keepFlags(keepFlags)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int clusterOf(int idx);
    case (idx % 4)
      0: return 0;
      2: return 1;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  // expected threshold for step s from the requirement formulas
  function automatic int refThr(int s, int mg);
    int cm[4]; int gm[4]; int ev; int od; int a; int b; int best; int r;
    for (int c = 0; c < 4; c++) begin cm[c] = 99999; gm[c] = 99999; end
    for (int i = 0; i < 64; i++) cm[clusterOf(i)] = imin(cm[clusterOf(i)], int'(pmH[s-2][i]));
    for (int j = 0; j < 16; j++) gm[clusterOf(j)] = imin(gm[clusterOf(j)], int'(bmH[s-1][j]));
    ev = 99999; od = 99999;
    for (int j = 0; j < 16; j++) begin
      if (j % 2 == 0) ev = imin(ev, int'(bmH[s][j]));
      else od = imin(od, int'(bmH[s][j]));
    end
    a = imin(imin(cm[0] + gm[0], cm[1] + gm[1]), imin(cm[2] + gm[3], cm[3] + gm[2]));
    b = imin(imin(cm[0] + gm[1], cm[1] + gm[0]), imin(cm[2] + gm[2], cm[3] + gm[3]));
    best = imin(a + ev, b + od);
    r = best + ((mg < 3) ? 3 : mg);
    return (r > 4095) ? 4095 : r;
  endfunction

  task automatic doStep(input string tag);
    int expThr; int k; int v; logic primedExp; logic [63:0] expFlags;
    @(negedge clk);
    for (int j = 0; j < 16; j++) begin
      bmH[t][j] = 8'(bmLo + int'($urandom % (bmHi - bmLo + 1)));
      branchMetrics[j*8 +: 8] = bmH[t][j];
    end
    primedExp = !rstV && (sinceRst >= 2);
    expThr = primedExp ? refThr(t, marginV) : 4095;
    for (int i = 0; i < 64; i++) begin
      v = pmBase + int'($urandom % (pmSpread + 1));
      pmH[t][i] = 12'((v > 4095) ? 4095 : v);
    end
    k = (t * 7) % 64;
    pmH[t][k] = 12'(expThr);
    if (expThr < 4095) pmH[t][(k + 1) % 64] = 12'(expThr + 1);
    if (expThr > 0) pmH[t][(k + 2) % 64] = 12'(expThr - 1);
    for (int i = 0; i < 64; i++) begin
      pathMetrics[i*12 +: 12] = pmH[t][i];
      expFlags[i] = !primedExp || (int'(pmH[t][i]) <= expThr);
    end
    rst = rstV;
    margin = 6'(marginV);
    #1;
    checks++;
    if (int'(threshold) != expThr) begin
      errors++;
      $display("FAIL %s step %0d threshold actual %0d expected %0d",
               primedExp ? tag : "R7", t, threshold, expThr);
    end
    checks++;
    if (keepFlags !== expFlags) begin
      errors++;
      $display("FAIL %s step %0d keepFlags actual %h expected %h",
               primedExp ? "R6" : "R7", t, keepFlags, expFlags);
    end
    t++;
    sinceRst = rstV ? 0 : sinceRst + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h1d2c3b);
    // R7: reset state
    rstV = 1'b1;
    repeat (3) doStep("R7");
    // R7 warm-up, then R1 R2 R3 R4 R6 random traffic
    rstV = 1'b0;
    for (int s = 0; s < 150; s++) begin
      pmBase = 400 + 5 * s;
      marginV = 3 + int'($urandom % 61);
      doStep("R1 R2 R3 R4");
    end
    // R4: margins below the floor
    for (int s = 0; s < 12; s++) begin
      marginV = s % 3;
      doStep("R4");
    end
    // R5: near full-scale metrics must saturate
    pmBase = 3990; pmSpread = 105; bmLo = 200; bmHi = 255; marginV = 63;
    repeat (12) doStep("R5");
    // R7: reset in the middle of the run
    pmBase = 1000; pmSpread = 150; bmLo = 0; bmHi = 255; marginV = 10;
    rstV = 1'b1;
    repeat (2) doStep("R7");
    rstV = 1'b0;
    repeat (4) doStep("R7");
    for (int s = 0; s < 20; s++) begin
      marginV = 3 + int'($urandom % 20);
      doStep("R1 R2 R3");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule